// File: doc/BRIEF.md
# Four-Channel Flash Converter Capture Encoder

This block sits behind four flash comparator ladders. Every channel presents a 15-bit thermometer code and a separate comparator bit that flags an input above positive full scale. A single sample strobe is shared by all channels. When an accepted strobe ends, the block turns each thermometer code into a 4-bit binary word and registers it together with the channel's overflow flag. The result then holds until the next accepted strobe ends.

The strobe comes from one of two places. It can be the external strobe pin, or it can be an internal free-running tick whose period is set in clock cycles. A veto input cancels strobes from either source. Each capture also emits a strobe-out pulse of programmable width, which starts in the same cycle as the new data. All inputs are synchronous to `clk`.

The strobe path is a three-state machine:
- **IDLE** waits for the registered strobe to go high. **IDLE→ARMED** fires when the strobe is high and veto is low. **IDLE→BLOCKED** fires when the strobe is high and veto is high.
- **ARMED** tracks a live strobe. **ARMED→BLOCKED (abort)** fires when veto rises before the strobe falls. **ARMED→IDLE (capture)** fires when the strobe falls with veto low. This is the only transition that updates the outputs.
- **BLOCKED** discards the rest of a vetoed strobe. **BLOCKED→IDLE** fires once the strobe is low.

Top module: `fcap_capture`

## Requirements
- R1: After reset, `data_out`, `ovf_out` and `strobe_out` are all 0.
- R2: On capture, channel c's field `data_out[4c+3:4c]` holds the number of set bits in `therm_in[15c+14:15c]`. For a contiguous thermometer code this gives a value from 0 to 15.
- R3: A thermometer code with gaps (bubbles) is encoded as its total count of set bits, regardless of where those bits are.
- R4: On capture, `ovf_out[c]` takes the value of `ovf_in[c]`. When that bit is 1, the channel's 4-bit field is forced to 4'hF if `ovf_all_ones` is 1, and to 4'h0 if it is 0.
- R5: Outputs change only on the capture transition, never at any other time. When the strobe input is driven low just after clock edge n, the new values appear after edge n+2.
- R6: A strobe that begins while veto is high is ignored in full: no output changes and no strobe-out pulse.
- R7: If veto rises while a strobe is high, that strobe is discarded even after veto falls again.
- R8: Each capture drives `strobe_out` high in the same cycle the new data appears. It stays high for `so_width`+1 clock cycles.
- R9: With `use_internal`=1, the external strobe pin is ignored. Captures then occur every `tick_period` cycles, with any period below 2 treated as 2.
- R10: Veto also suppresses captures from the internal strobe source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| therm_in | input | 60 | Thermometer codes; channel c uses bits [15c+14:15c] |
| ovf_in | input | 4 | Positive-overflow comparator bit, one per channel |
| ext_strobe | input | 1 | External sample strobe |
| use_internal | input | 1 | 1 selects the internal free-running strobe |
| tick_period | input | 8 | Internal strobe period in clock cycles |
| veto | input | 1 | Suppresses strobes while high |
| ovf_all_ones | input | 1 | Static setting: forced word on overflow is all ones (1) or all zeros (0) |
| so_width | input | 4 | Strobe-out width minus one, in clock cycles |
| data_out | output | 16 | Latched 4-bit words; channel c uses bits [4c+3:4c] |
| ovf_out | output | 4 | Latched overflow flags |
| strobe_out | output | 1 | Pulse marking fresh data |

## Verification
The strobe machine is the only source of the capture event, so a wrong state shows up as a capture that should not happen or a missing one. Either way, the port effect appears within two cycles of the strobe's falling edge: `data_out` changes or fails to change, and a `strobe_out` pulse appears or does not. A machine stuck in BLOCKED makes every later strobe disappear. A machine that skips the abort path shows up as a vetoed strobe that still updates the data. The internal tick counter is observed as the spacing between `strobe_out` pulses, so an off-by-one in its reload value shows directly in that spacing.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_BLOCKED = 2'd2
    } strobe_st_t;
endpackage

// File: rtl/fcap_tick_gen.sv
module fcap_tick_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] reload;

    // a period below 2 is clamped to 2 so the tick always drops between pulses
    assign reload = (period < PER_W'(2)) ? PER_W'(1) : period - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == '0);
            cnt  <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    // R9: a tick is never longer than one cycle
    assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/fcap_strobe_fsm.sv
module fcap_strobe_fsm
    import fcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic veto,
    output logic capture
);
    strobe_st_t state, nxt;
    logic       src_q, veto_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= 1'b0;
            veto_q <= 1'b0;
        end else begin
            src_q  <= src;
            veto_q <= veto;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (src_q) nxt = veto_q ? ST_BLOCKED : ST_ARMED;
            end
            ST_ARMED: begin
                if (veto_q)      nxt = ST_BLOCKED;
                else if (!src_q) nxt = ST_IDLE;
            end
            ST_BLOCKED: begin
                if (!src_q) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        unique case (state)
            ST_ARMED:   capture = !veto_q && !src_q;
            ST_IDLE,
            ST_BLOCKED: capture = 1'b0;
            default:    capture = 1'b0;
        endcase
    end

    // R7: an aborted strobe cannot capture in the following cycle
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && veto_q) |=> !capture);
    // R6: BLOCKED is left only through IDLE
    assert_blocked_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCKED) |=> (state != ST_ARMED));
endmodule

// File: rtl/fcap_thermo_enc.sv
module fcap_thermo_enc #(
    parameter  int TH_W   = 15,
    localparam int CODE_W = $clog2(TH_W + 1)
) (
    input  logic [TH_W-1:0]   therm,
    input  logic              ovf,
    input  logic              all_ones,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] ones;

    // counting set bits absorbs bubbles in the ladder
    always_comb begin
        ones = '0;
        for (int i = 0; i < TH_W; i++) ones = ones + CODE_W'(therm[i]);
    end

    assign code = ovf ? {CODE_W{all_ones}} : ones;
endmodule

// File: rtl/fcap_capture.sv
module fcap_capture
    import fcap_pkg::*;
#(
    parameter  int N_CH   = 4,
    parameter  int TH_W   = 15,
    parameter  int PER_W  = 8,
    parameter  int SOW_W  = 4,
    localparam int CODE_W = $clog2(TH_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*TH_W-1:0]     therm_in,
    input  logic [N_CH-1:0]          ovf_in,
    input  logic                     ext_strobe,
    input  logic                     use_internal,
    input  logic [PER_W-1:0]         tick_period,
    input  logic                     veto,
    input  logic                     ovf_all_ones,
    input  logic [SOW_W-1:0]         so_width,
    output logic [N_CH*CODE_W-1:0]   data_out,
    output logic [N_CH-1:0]          ovf_out,
    output logic                     strobe_out
);
    logic                   int_tick;
    logic                   src_sel;
    logic                   capture;
    logic [N_CH*CODE_W-1:0] code_all;
    logic [SOW_W-1:0]       so_cnt;

    fcap_tick_gen #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(int_tick)
    );

    assign src_sel = use_internal ? int_tick : ext_strobe;

    fcap_strobe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .src(src_sel), .veto(veto), .capture(capture)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        fcap_thermo_enc #(.TH_W(TH_W)) u_enc (
            .therm   (therm_in[c*TH_W +: TH_W]),
            .ovf     (ovf_in[c]),
            .all_ones(ovf_all_ones),
            .code    (code_all[c*CODE_W +: CODE_W])
        );

        // R4: an overflowed channel carries the forced word
        assert_ovf_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (capture && ovf_in[c]) |=>
                (data_out[c*CODE_W +: CODE_W] == {CODE_W{$past(ovf_all_ones)}}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            ovf_out  <= '0;
        end else if (capture) begin
            data_out <= code_all;
            ovf_out  <= ovf_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_out <= 1'b0;
            so_cnt     <= '0;
        end else if (capture) begin
            strobe_out <= 1'b1;
            so_cnt     <= so_width;
        end else if (strobe_out) begin
            if (so_cnt == '0) strobe_out <= 1'b0;
            else              so_cnt     <= so_cnt - 1'b1;
        end
    end

    // R5: outputs hold without a capture
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(data_out) && $stable(ovf_out)));
    // R6: no capture follows a cycle with veto high
    assert_veto_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !$past(veto));
    // R8: strobe-out starts together with fresh data
    assert_so_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> strobe_out);
    // R4: overflow flags follow the comparator bits at capture
    assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ovf_out == $past(ovf_in)));
endmodule

// File: tb/sim_fcap_capture.sv
module sim_fcap_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [59:0] therm_in = '0;
    logic [3:0]  ovf_in = '0;
    logic        ext_strobe = 1'b0;
    logic        use_internal = 1'b0;
    logic [7:0]  tick_period = 8'd10;
    logic        veto = 1'b0;
    logic        ovf_all_ones = 1'b0;
    logic [3:0]  so_width = '0;
    logic [15:0] data_out;
    logic [3:0]  ovf_out;
    logic        strobe_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fcap_capture u0 (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in), .ovf_in(ovf_in),
        .ext_strobe(ext_strobe), .use_internal(use_internal),
        .tick_period(tick_period), .veto(veto), .ovf_all_ones(ovf_all_ones),
        .so_width(so_width), .data_out(data_out), .ovf_out(ovf_out),
        .strobe_out(strobe_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] thermo(input int n);
        return 15'(((32'd1 << n) - 1));
    endfunction

    // pulse the external strobe; returns at the negedge where new data must show
    task automatic ext_pulse(input int hi, output logic [15:0] mid_data);
        @(negedge clk); ext_strobe = 1'b1;
        repeat (hi) @(negedge clk);
        ext_strobe = 1'b0;
        @(negedge clk); mid_data = data_out;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 data", 32'(data_out), 0);
        check("R1 ovf", 32'(ovf_out), 0);
        check("R1 strobe_out", 32'(strobe_out), 0);
    endtask

    task automatic t_encode;
        logic [15:0] mid;
        therm_in = {thermo(15), thermo(9), thermo(5), thermo(0)};
        ext_pulse(2, mid);
        check("R5 no early update", 32'(mid), 0);
        check("R2 contiguous codes", 32'(data_out), 32'hF950);
        check("R8 strobe_out with data", 32'(strobe_out), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_bubble;
        logic [15:0] mid;
        therm_in = {15'h0100, 15'h7FFE, 15'h5555, 15'h002D};
        ext_pulse(1, mid);
        check("R3 bubble count", 32'(data_out), 32'h1E84);
    endtask

    task automatic t_hold;
        therm_in = '0;
        ovf_in = 4'hF;
        repeat (10) @(negedge clk);
        check("R5 data hold", 32'(data_out), 32'h1E84);
        check("R5 ovf hold", 32'(ovf_out), 0);
        ovf_in = '0;
    endtask

    task automatic t_overflow;
        logic [15:0] mid;
        therm_in = {4{thermo(3)}};
        ovf_in = 4'b0101;
        ovf_all_ones = 1'b1;
        ext_pulse(2, mid);
        check("R4 forced ones", 32'(data_out), 32'h3F3F);
        check("R4 ovf flags", 32'(ovf_out), 32'h5);
        ovf_all_ones = 1'b0;
        ext_pulse(2, mid);
        check("R4 forced zeros", 32'(data_out), 32'h3030);
        ovf_in = '0;
        ext_pulse(1, mid);
        check("R4 flags cleared", 32'(ovf_out), 0);
    endtask

    task automatic t_width;
        logic [15:0] mid;
        int highs;
        so_width = 4'd3;
        therm_in = {4{thermo(2)}};
        ext_pulse(1, mid);
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            if (strobe_out) highs++;
            @(negedge clk);
        end
        check("R8 pulse width", 32'(highs), 4);
        check("R8 data with pulse", 32'(data_out), 32'h2222);
        so_width = '0;
    endtask

    task automatic t_veto_full;
        int highs = 0;
        therm_in = {4{thermo(7)}};
        @(negedge clk); veto = 1'b1;
        @(negedge clk); ext_strobe = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); if (strobe_out) highs++; end
        ext_strobe = 1'b0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); if (strobe_out) highs++; end
        veto = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (strobe_out) highs++; end
        check("R6 vetoed data", 32'(data_out), 32'h2222);
        check("R6 vetoed pulse", 32'(highs), 0);
    endtask

    task automatic t_veto_mid;
        int highs = 0;
        @(negedge clk); ext_strobe = 1'b1;
        repeat (3) @(negedge clk);
        veto = 1'b1;
        @(negedge clk); ext_strobe = 1'b0;
        @(negedge clk); veto = 1'b0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (strobe_out) highs++; end
        check("R7 aborted data", 32'(data_out), 32'h2222);
        check("R7 aborted pulse", 32'(highs), 0);
    endtask

    task automatic t_after_veto;
        logic [15:0] mid;
        ext_pulse(2, mid);
        check("R6 accepted after veto", 32'(data_out), 32'h7777);
    endtask

    task automatic t_internal;
        int first = -1;
        int second = -1;
        therm_in = {4{thermo(11)}};
        veto = 1'b1;
        @(negedge clk);
        use_internal = 1'b1;
        tick_period = 8'd10;
        ext_strobe = 1'b1;   // held high: would never fall if it were used
        repeat (3) @(negedge clk);
        veto = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (strobe_out) begin
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
        end
        check("R9 internal pulse seen", 32'(first >= 0), 1);
        check("R9 internal period", 32'(second - first), 10);
        check("R9 internal data", 32'(data_out), 32'hBBBB);
    endtask

    task automatic t_int_veto;
        int highs = 0;
        therm_in = {4{thermo(1)}};
        veto = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (strobe_out) highs++; end
        check("R10 internal vetoed pulse", 32'(highs), 0);
        check("R10 internal vetoed data", 32'(data_out), 32'hBBBB);
        use_internal = 1'b0;
        ext_strobe = 1'b0;
        repeat (3) @(negedge clk);
        veto = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_encode();
        t_bubble();
        t_hold();
        t_overflow();
        t_width();
        t_veto_full();
        t_veto_mid();
        t_after_veto();
        t_internal();
        t_int_veto();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule